// File: doc/BRIEF.md
# Core Boot and Fault-Halt Controller

This block sits beside a 32-bit processor core and owns the start-up path and the unrecoverable fault path. A synchronous reset has priority over everything else. It abandons whatever the controller was doing and places the status register in a defined supervisor state. It also clears the vector base and disables every local-memory configuration slot. Once reset is released and the core holds the bus, the controller makes two single-word reads. The first reads address zero and supplies the initial stack pointer. The second reads the next word and supplies the initial program counter. It then releases the core to fetch its first instruction.

The controller also tracks faults. A bus error during either boot read, or a core-reported fault before the first instruction completes, locks the core in a halt. During normal running, a second fault that arrives while the exception for an earlier fault is still in progress also locks the core. Only reset leaves the halt. The status register, vector base and memory configuration slots can be written by the core only in the running state.

Top module: `core_boot_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `sr` equals 16'h2700. This means trace bit 15 = 0, supervisor bit 13 = 1, master bit 12 = 0 and priority mask bits [10:8] = 7. In the same cycle `vbr` = 0, every `mem_cfg` slot = 0 (bit 0 of a slot is its enable), and `halted`, `run_en`, `bus_req` and `boot_done` are all 0.
- R2: Reset asserted in any state, including mid-read and halted, returns every output to its R1 value at the next clock edge.
- R3: While `bus_own` is low after reset, `bus_req` stays low. The first read starts on the edge that samples `bus_own` high.
- R4: The first read uses address 0 and its data becomes the stack pointer. The second read uses address 4 (one 32-bit word on) and its data becomes the program counter.
- R5: Once `bus_req` is high, it and `bus_addr` hold steady until a cycle with `bus_ready` or `bus_err`. Only one read is outstanding at a time.
- R6: On the edge that accepts the second read, `boot_done` pulses for exactly one cycle. In that cycle `boot_sp` and `boot_pc` show the loaded values and `run_en` goes high, and it stays high while not halted.
- R7: `bus_err` during either boot read makes `halted` = 1 at the next edge, with `bus_req` = 0 and no `boot_done`.
- R8: `core_fault` after release but before `first_exec` halts the core.
- R9: In the running state, one `core_fault` starts a fault exception that `exc_done` ends without a halt. A `core_fault` while such an exception is open halts the core.
- R10: Once halted, `halted` stays 1, and `run_en` and `bus_req` stay 0, whatever the other inputs do, until reset.
- R11: Writes to `sr`, `vbr` or a `mem_cfg` slot take effect one edge later, and only in the running state. At any other time they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (reset exception) |
| bus_own | input | 1 | Core currently owns the bus |
| bus_req | output | 1 | Read request, held until answered |
| bus_addr | output | AW | Read address |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| bus_ready | input | 1 | Read completed |
| bus_err | input | 1 | Read terminated with an access or address error |
| core_fault | input | 1 | Core detected an access or address fault (one-cycle pulse) |
| exc_done | input | 1 | Core finished processing the open fault exception |
| first_exec | input | 1 | Core completed its first instruction |
| run_en | output | 1 | Core may fetch and execute |
| boot_done | output | 1 | One-cycle pulse at release |
| boot_sp | output | DW | Loaded stack pointer |
| boot_pc | output | DW | Loaded program counter |
| halted | output | 1 | Core is locked in the fault halt |
| sr_we | input | 1 | Status register write strobe |
| sr_wdata | input | 16 | Status register write data |
| vbr_we | input | 1 | Vector base write strobe |
| vbr_wdata | input | AW | Vector base write data |
| sr | output | 16 | Status register |
| vbr | output | AW | Vector base register |
| mem_cfg_we | input | NMEM | Per-slot configuration write strobes |
| mem_cfg_wdata | input | CW | Configuration write data |
| mem_cfg | output | NMEM*CW | All configuration slots, slot 0 in the low bits |

## Verification
The hardest condition to reach is the halt caused by a fault on top of a fault. It requires the run state, one fault accepted and not yet closed by `exc_done`, and then a second fault. The stimulus walks through release and `first_exec`, then sends a fault, closes it, and sends a fault pair with random gaps between them. Boot-time errors need a request that has been held for a random number of cycles, so the bench answers each read after a random delay and injects `bus_err` in place of `bus_ready` at a chosen read.

// File: rtl/core_boot_pkg.sv
package core_boot_pkg;
  typedef enum logic [2:0] {
    ST_WAITBUS,
    ST_SP,
    ST_PC,
    ST_FIRST,
    ST_RUN,
    ST_HALT
  } boot_st_t;

  localparam int SR_W       = 16;
  localparam int SR_T_BIT   = 15;
  localparam int SR_S_BIT   = 13;
  localparam int SR_M_BIT   = 12;
  localparam int SR_IPL_LSB = 8;
  localparam logic [SR_W-1:0] SR_RESET =
    SR_W'((1 << SR_S_BIT) | (7 << SR_IPL_LSB));
endpackage

// File: rtl/boot_seq.sv
module boot_seq
  import core_boot_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_own,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic          core_fault,
  input  logic          exc_done,
  input  logic          first_exec,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] boot_sp,
  output logic [DW-1:0] boot_pc,
  output logic          boot_done,
  output logic          run_en,
  output logic          halted,
  output logic          wr_allow
);
  localparam int WORD_BYTES = DW / 8;

  boot_st_t st;
  logic     in_exc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_WAITBUS;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      boot_sp   <= '0;
      boot_pc   <= '0;
      boot_done <= 1'b0;
      run_en    <= 1'b0;
      halted    <= 1'b0;
      in_exc    <= 1'b0;
    end else begin
      boot_done <= 1'b0;
      case (st)
        ST_WAITBUS: if (bus_own) begin
          st       <= ST_SP;
          bus_req  <= 1'b1;
          bus_addr <= '0;
        end
        ST_SP: if (bus_err) begin
          st      <= ST_HALT;
          bus_req <= 1'b0;
          halted  <= 1'b1;
        end else if (bus_ready) begin
          boot_sp  <= bus_rdata;
          bus_addr <= AW'(WORD_BYTES);
          st       <= ST_PC;
        end
        ST_PC: if (bus_err) begin
          st      <= ST_HALT;
          bus_req <= 1'b0;
          halted  <= 1'b1;
        end else if (bus_ready) begin
          boot_pc   <= bus_rdata;
          bus_req   <= 1'b0;
          boot_done <= 1'b1;
          run_en    <= 1'b1;
          st        <= ST_FIRST;
        end
        ST_FIRST: if (core_fault) begin
          st     <= ST_HALT;
          run_en <= 1'b0;
          halted <= 1'b1;
        end else if (first_exec) begin
          st <= ST_RUN;
        end
        ST_RUN: if (core_fault) begin
          if (in_exc) begin
            st     <= ST_HALT;
            run_en <= 1'b0;
            halted <= 1'b1;
          end else begin
            in_exc <= 1'b1;
          end
        end else if (exc_done) begin
          in_exc <= 1'b0;
        end
        default: begin
          st      <= ST_HALT;
          bus_req <= 1'b0;
          run_en  <= 1'b0;
          halted  <= 1'b1;
        end
      endcase
    end
  end

  assign wr_allow = (st == ST_RUN);

  // R3
  no_req_without_own_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && !bus_own) |=> !bus_req);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready && !bus_err) |=> (bus_req && $stable(bus_addr)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> !boot_done);
  // R6
  done_with_run_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done |-> (run_en && !bus_req));
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!run_en && !bus_req && !boot_done));
endmodule

// File: rtl/sr_regs.sv
module sr_regs
  import core_boot_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_allow,
  input  logic            sr_we,
  input  logic [SR_W-1:0] sr_wdata,
  input  logic            vbr_we,
  input  logic [AW-1:0]   vbr_wdata,
  output logic [SR_W-1:0] sr_q,
  output logic [AW-1:0]   vbr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= SR_RESET;
      vbr_q <= '0;
    end else if (wr_allow) begin
      if (sr_we)  sr_q  <= sr_wdata;
      if (vbr_we) vbr_q <= vbr_wdata;
    end
  end

  // R1
  sr_reset_val_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sr_q[SR_S_BIT] && !sr_q[SR_T_BIT] && !sr_q[SR_M_BIT]
                    && sr_q[SR_IPL_LSB+:3] == 3'd7 && vbr_q == '0));
  // R11
  sr_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_allow |=> ($stable(sr_q) && $stable(vbr_q)));
endmodule

// File: rtl/mem_cfg_bank.sv
module mem_cfg_bank #(
  parameter int NMEM = 2,
  parameter int CW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_allow,
  input  logic [NMEM-1:0]    we,
  input  logic [CW-1:0]      wdata,
  output logic [NMEM*CW-1:0] cfg_q
);
  for (genvar g = 0; g < NMEM; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g*CW +: CW] <= '0;
      else if (wr_allow && we[g])
        cfg_q[g*CW +: CW] <= wdata;
    end
  end

  // R11
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_allow |=> $stable(cfg_q));
  // R1
  cfg_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == '0));
endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl
  import core_boot_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NMEM = 2,
  parameter int CW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_own,
  output logic               bus_req,
  output logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               bus_ready,
  input  logic               bus_err,
  input  logic               core_fault,
  input  logic               exc_done,
  input  logic               first_exec,
  output logic               run_en,
  output logic               boot_done,
  output logic [DW-1:0]      boot_sp,
  output logic [DW-1:0]      boot_pc,
  output logic               halted,
  input  logic               sr_we,
  input  logic [SR_W-1:0]    sr_wdata,
  input  logic               vbr_we,
  input  logic [AW-1:0]      vbr_wdata,
  output logic [SR_W-1:0]    sr,
  output logic [AW-1:0]      vbr,
  input  logic [NMEM-1:0]    mem_cfg_we,
  input  logic [CW-1:0]      mem_cfg_wdata,
  output logic [NMEM*CW-1:0] mem_cfg
);
  logic wr_allow;

  boot_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .bus_own    (bus_own),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .core_fault (core_fault),
    .exc_done   (exc_done),
    .first_exec (first_exec),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .boot_sp    (boot_sp),
    .boot_pc    (boot_pc),
    .boot_done  (boot_done),
    .run_en     (run_en),
    .halted     (halted),
    .wr_allow   (wr_allow)
  );

  sr_regs #(.AW(AW)) u_sr (
    .clk       (clk),
    .rst       (rst),
    .wr_allow  (wr_allow),
    .sr_we     (sr_we),
    .sr_wdata  (sr_wdata),
    .vbr_we    (vbr_we),
    .vbr_wdata (vbr_wdata),
    .sr_q      (sr),
    .vbr_q     (vbr)
  );

  mem_cfg_bank #(.NMEM(NMEM), .CW(CW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_allow (wr_allow),
    .we       (mem_cfg_we),
    .wdata    (mem_cfg_wdata),
    .cfg_q    (mem_cfg)
  );
endmodule

// File: tb/core_boot_ctrl_test.sv
module core_boot_ctrl_test;
  localparam int AW = 32, DW = 32, NMEM = 2, CW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_own = 0, bus_ready = 0, bus_err = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic core_fault = 0, exc_done = 0, first_exec = 0;
  logic sr_we = 0, vbr_we = 0;
  logic [15:0] sr_wdata = '0;
  logic [AW-1:0] vbr_wdata = '0;
  logic [NMEM-1:0] mem_cfg_we = '0;
  logic [CW-1:0] mem_cfg_wdata = '0;
  logic bus_req, run_en, boot_done, halted;
  logic [AW-1:0] bus_addr, vbr;
  logic [DW-1:0] boot_sp, boot_pc;
  logic [15:0] sr;
  logic [NMEM*CW-1:0] mem_cfg;

  int checks = 0, failures = 0;
  bit finished = 0;

  core_boot_ctrl #(.AW(AW), .DW(DW), .NMEM(NMEM), .CW(CW)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [15:0] exp_sr_reset();
    logic [15:0] v = '0;
    v[13] = 1'b1;
    v[10:8] = 3'd7;
    return v;
  endfunction

  function automatic logic [AW-1:0] exp_addr(int idx);
    return AW'(idx * 4);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    bus_own = 0; bus_ready = 0; bus_err = 0; core_fault = 0; exc_done = 0;
    first_exec = 0; sr_we = 0; vbr_we = 0; mem_cfg_we = '0;
  endtask

  task automatic check_reset_state(string req);
    check(req, "sr", 64'(sr), 64'(exp_sr_reset()));
    check(req, "vbr", 64'(vbr), 64'd0);
    check(req, "mem_cfg", 64'(mem_cfg), 64'd0);
    check(req, "halted/run/req/done", {60'd0, halted, run_en, bus_req, boot_done}, 64'd0);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    tick(); tick();
    rst = 0;
    tick();
  endtask

  // err_stage: 0 none, 1 error on the first read, 2 error on the second read
  task automatic boot(int own_dly, int d1, int d2, logic [DW-1:0] sp,
                      logic [DW-1:0] pc, int err_stage);
    for (int i = 0; i < own_dly; i++) begin
      check("R3", "req without ownership", 64'(bus_req), 64'd0);
      tick();
    end
    bus_own = 1;
    tick();
    check("R4", "first read req/addr", {31'd0, bus_req, bus_addr}, {31'd1, exp_addr(0)});
    for (int i = 0; i < d1; i++) begin
      tick();
      check("R5", "hold first read", {31'd0, bus_req, bus_addr}, {31'd1, exp_addr(0)});
    end
    if (err_stage == 1) begin
      bus_err = 1; tick(); bus_err = 0;
      check("R7", "halt on first read error", {61'd0, halted, bus_req, boot_done}, 64'd4);
      return;
    end
    bus_ready = 1; bus_rdata = sp; tick(); bus_ready = 0;
    check("R4", "second read req/addr", {31'd0, bus_req, bus_addr}, {31'd1, exp_addr(1)});
    for (int i = 0; i < d2; i++) begin
      tick();
      check("R5", "hold second read", {31'd0, bus_req, bus_addr}, {31'd1, exp_addr(1)});
    end
    if (err_stage == 2) begin
      bus_err = 1; tick(); bus_err = 0;
      check("R7", "halt on second read error", {61'd0, halted, bus_req, boot_done}, 64'd4);
      return;
    end
    bus_ready = 1; bus_rdata = pc; tick(); bus_ready = 0;
    check("R6", "release done/run/req", {61'd0, boot_done, run_en, bus_req}, 64'd6);
    check("R4", "stack pointer", 64'(boot_sp), 64'(sp));
    check("R4", "program counter", 64'(boot_pc), 64'(pc));
    tick();
    check("R6", "done lasts one cycle", {62'd0, boot_done, run_en}, 64'd1);
  endtask

  task automatic check_halt_hold(int n);
    for (int i = 0; i < n; i++) begin
      bus_own = 1'($urandom); bus_ready = 1'($urandom); first_exec = 1'($urandom);
      core_fault = 1'($urandom); exc_done = 1'($urandom);
      sr_we = 1; sr_wdata = 16'($urandom); mem_cfg_we = '1;
      mem_cfg_wdata = 8'($urandom);
      tick();
      check("R10", "halt holds", {61'd0, halted, run_en, bus_req}, 64'd4);
    end
    check("R11", "sr untouched in halt", 64'(sr), 64'(exp_sr_reset()));
    check("R11", "cfg untouched in halt", 64'(mem_cfg), 64'd0);
    idle_inputs();
  endtask

  initial begin
    void'($urandom(32'd4711));

    do_reset();
    check_reset_state("R1");

    // R11: writes before running are ignored
    sr_we = 1; sr_wdata = 16'h0000; vbr_we = 1; vbr_wdata = 32'hdead0000;
    mem_cfg_we = '1; mem_cfg_wdata = 8'hff;
    tick();
    idle_inputs();
    check("R11", "sr write before run", 64'(sr), 64'(exp_sr_reset()));
    check("R11", "vbr write before run", 64'(vbr), 64'd0);
    check("R11", "cfg write before run", 64'(mem_cfg), 64'd0);

    // random boots through run, fault handling and fault-on-fault
    for (int it = 0; it < 6; it++) begin
      logic [DW-1:0] sp = $urandom, pc = $urandom;
      logic [15:0] srv = 16'($urandom);
      logic [AW-1:0] vb = $urandom;
      logic [CW-1:0] cw = 8'($urandom);
      int slot = it % NMEM;
      do_reset();
      check_reset_state("R1");
      boot(int'($urandom_range(0, 5)), int'($urandom_range(0, 4)),
           int'($urandom_range(0, 4)), sp, pc, 0);
      sr_we = 1; sr_wdata = srv; tick(); sr_we = 0;
      check("R11", "sr write in FIRST ignored", 64'(sr), 64'(exp_sr_reset()));
      first_exec = 1; tick(); first_exec = 0;
      sr_we = 1; sr_wdata = srv; vbr_we = 1; vbr_wdata = vb;
      mem_cfg_we = '0; mem_cfg_we[slot] = 1'b1; mem_cfg_wdata = cw;
      tick();
      idle_inputs();
      check("R11", "sr write in run", 64'(sr), 64'(srv));
      check("R11", "vbr write in run", 64'(vbr), 64'(vb));
      check("R11", "cfg slot write", 64'(mem_cfg), 64'(cw) << (slot * CW));
      core_fault = 1; tick(); core_fault = 0;
      check("R9", "single fault no halt", 64'(halted), 64'd0);
      repeat (int'($urandom_range(0, 3))) tick();
      exc_done = 1; tick(); exc_done = 0;
      core_fault = 1; tick(); core_fault = 0;
      check("R9", "fault after close no halt", {62'd0, halted, run_en}, 64'd1);
      repeat (int'($urandom_range(0, 3))) tick();
      core_fault = 1; tick(); core_fault = 0;
      check("R9", "fault on fault halts", {62'd0, halted, run_en}, 64'd2);
      tick();
      check("R10", "halted stays", 64'(halted), 64'd1);
      rst = 1; tick(); rst = 0;
      check("R2", "reset leaves halt", {61'd0, halted, run_en, bus_req}, 64'd0);
      check("R2", "reset restores sr", 64'(sr), 64'(exp_sr_reset()));
      check("R2", "reset clears cfg", 64'(mem_cfg), 64'd0);
    end

    // R7: bus error on each read, then R10 persistence
    do_reset();
    boot(1, 2, 0, 32'h1111, 32'h2222, 1);
    check_halt_hold(8);
    do_reset();
    boot(0, 0, 3, 32'h3333, 32'h4444, 2);
    check("R7", "no release after error", 64'(run_en), 64'd0);
    check_halt_hold(8);

    // R8: fault between release and first instruction
    do_reset();
    boot(2, 1, 1, 32'h0000_1000, 32'h0000_0400, 0);
    core_fault = 1; tick(); core_fault = 0;
    check("R8", "fault before first instruction", {62'd0, halted, run_en}, 64'd2);
    check_halt_hold(4);

    // R2: reset in the middle of a read
    do_reset();
    bus_own = 1; tick(); tick();
    check("R5", "request outstanding", 64'(bus_req), 64'd1);
    rst = 1; tick(); rst = 0; bus_own = 0;
    check("R2", "reset aborts read", {62'd0, bus_req, boot_done}, 64'd0);
    tick();
    check_reset_state("R2");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule